// File: doc/BRIEF.md
# Acquisition Sequencer Control Register

This block is the command and status word of a data-acquisition sequencer. Software writes one 16-bit word to start or halt the sequencer, to fire a system reset, to ask for a short offset correction or a full calibration, to enter or leave low-power standby, and to set several static modes. Reading the same word back shows whether the sequencer runs, whether a reset is in progress and which calibration is still outstanding.

Every command becomes a strobe or level with fixed timing. A halt takes effect only when the running instruction reports completion. A calibration requested while the sequencer runs waits for that completion, pauses the sequencer for its fixed length and then lets it resume. Reset and the exit from standby both drive the same short clearing sequence for the instruction pointer, the conversion FIFO and the interrupt flags. Calibration lengths are counted by internal counters. The converter, the instruction memory and the analog work stay outside the block.

Top module: `acq_ctrl_reg`

## Requirements
- R1: Writing a word with bit 0 = 1 makes bit 0 read 1 and `seq_run` high from the next cycle. Writing bit 0 = 0 while running leaves both high until `instr_done` is sampled high; they drop the cycle after that.
- R2: A write with bit 1 = 1 makes bit 1 read 1 for exactly the two following cycles. During those cycles `ip_reset`, `fifo_clr` and `irq_clr_all` are high, bit 0 reads 0 and `seq_run` is low. Any pending or running calibration is cancelled without its interrupt strobe, and writes of bits 0, 2 and 3 are ignored while bit 1 reads 1.
- R3: After `rst_n` is released, bit 1 reads 1 for the current cycle and the one after it, with the clearing strobes high, and then the whole word reads 0.
- R4: With the sequencer stopped, a write of bit 2 = 1 starts a short offset correction at once. Bit 2 reads 1 for 76 cycles, `irq_set_az` is high for one cycle in the 76th, and bit 2 reads 0 afterwards.
- R5: A write of bit 3 = 1 runs a full calibration under the same rules for 4944 cycles, with a single `irq_set_cal` strobe in the last cycle. If bits 2 and 3 are written together, only the full calibration runs. A request written while another calibration is pending or running is ignored.
- R6: If the sequencer runs, a calibration request keeps bit 2 or 3 at 1 but starts counting only at the edge where `instr_done` is sampled high. `seq_run` is low from that edge until the strobe cycle and returns high in the following cycle.
- R7: A write with bit 4 = 1 puts the block in standby from the next cycle. `clk_en` goes low, bit 1 reads 1 with the clearing strobes high, and bit 0 reads 0. Bits 5 to 10 keep their values.
- R8: A write with bit 4 = 0 while in standby raises `clk_en` from the next cycle and makes bit 1 read 1 for two cycles. `irq_set_stby` is high for one cycle, in the SETTLE_CYC-th cycle after the write.
- R9: Bit 7 = 1 drives `sync_oe` high and makes `sync_out` follow `conv_busy`. With bit 7 = 0, `sync_out` is low, and a low-to-high change of `sync_in` gives a one-cycle `sync_trig` in the cycle after the first edge that samples it high. In output mode `sync_trig` stays low.
- R10: Bit 5 drives `chan_mask`, bit 6 drives `az_each_conv` and bits 9:8 drive `ram_sect`. Bit 10 is stored and read back with no effect, and bits 15:11 read 0. A write of 11 to bits 9:8 leaves the section field unchanged.
- R11: While in standby, bits 0, 2 and 3 of a write are ignored. Bits 5 to 10, including the section select, can still be written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Control word written |
| rd_data | output | 16 | Control and status word read back |
| instr_done | input | 1 | The running instruction finished this cycle |
| conv_busy | input | 1 | A conversion or limit comparison is in progress |
| sync_in | input | 1 | Sync pad input level |
| seq_run | output | 1 | Sequencer may fetch and execute instructions |
| ip_reset | output | 1 | Force the instruction pointer to zero |
| fifo_clr | output | 1 | Clear the conversion FIFO |
| irq_clr_all | output | 1 | Clear every interrupt flag |
| irq_set_az | output | 1 | Set the short-correction-done flag |
| irq_set_cal | output | 1 | Set the full-calibration-done flag |
| irq_set_stby | output | 1 | Set the standby-complete flag |
| clk_en | output | 1 | Enable for the internal clock gate |
| chan_mask | output | 1 | Conversion words carry sign extension instead of pointer |
| az_each_conv | output | 1 | Insert an offset correction before each conversion |
| ram_sect | output | 2 | Instruction word section selected for access |
| sync_oe | output | 1 | Sync pad output enable |
| sync_out | output | 1 | Sync pad output level |
| sync_trig | output | 1 | Conversion start from a sync input rising edge |

## Verification
The bench builds the block with the default calibration lengths of 76 and 4944 cycles, so both strobes are checked at their exact cycle, including the full count. The reset pulse stays at its default of two cycles. The standby settling delay is lowered to 16 cycles, which keeps the exit from standby and its completion strobe within a short run while still giving a window that can be told apart from the reset pulse.

// File: rtl/acq_ctrl_pkg.sv
package acq_ctrl_pkg;

    localparam int REG_W   = 16;
    localparam int SECT_W  = 2;

    // bit positions inside the control word
    localparam int B_RUN   = 0;
    localparam int B_RST   = 1;
    localparam int B_AZ    = 2;
    localparam int B_CAL   = 3;
    localparam int B_STBY  = 4;
    localparam int B_MASK  = 5;
    localparam int B_AZC   = 6;
    localparam int B_SDIR  = 7;
    localparam int B_SECT  = 8;
    localparam int B_TEST  = 10;

    localparam logic [SECT_W-1:0] SECT_BAD = 2'b11;

    typedef enum logic [1:0] {
        CAL_IDLE,
        CAL_WAIT,
        CAL_BUSY
    } cal_st_e;

    typedef struct packed {
        logic              test;
        logic [SECT_W-1:0] sect;
        logic              sync_dir;
        logic              az_each;
        logic              mask;
        logic              stby;
        logic              run;
        logic              stop_pend;
    } ctl_t;

endpackage

// File: rtl/acq_cal_engine.sv
module acq_cal_engine
    import acq_ctrl_pkg::*;
#(
    parameter int SHORT_CYC = 76,
    parameter int FULL_CYC  = 4944
) (
    input  logic clk,
    input  logic rst_n,
    input  logic abort,
    input  logic req_short,
    input  logic req_full,
    input  logic seq_running,
    input  logic instr_done,
    output logic pend_short,
    output logic pend_full,
    output logic busy,
    output logic done_short,
    output logic done_full
);

    localparam int MAX_CYC = (FULL_CYC > SHORT_CYC) ? FULL_CYC : SHORT_CYC;
    localparam int CW      = $clog2(MAX_CYC + 1);

    typedef struct packed {
        cal_st_e       st;
        logic          full;
        logic [CW-1:0] cnt;
    } eng_t;

    eng_t q, d;
    logic fin;

    always_comb begin
        d   = q;
        fin = 1'b0;
        unique case (q.st)
            CAL_IDLE: begin
                if (req_full || req_short) begin
                    d.full = req_full;
                    if (!seq_running) begin
                        d.st  = CAL_BUSY;
                        d.cnt = req_full ? CW'(FULL_CYC) : CW'(SHORT_CYC);
                    end else begin
                        d.st  = CAL_WAIT;
                    end
                end
            end
            CAL_WAIT: begin
                // hold off until the running instruction ends
                if (instr_done || !seq_running) begin
                    d.st  = CAL_BUSY;
                    d.cnt = q.full ? CW'(FULL_CYC) : CW'(SHORT_CYC);
                end
            end
            CAL_BUSY: begin
                if (q.cnt == CW'(1)) begin
                    d.st  = CAL_IDLE;
                    d.cnt = '0;
                    fin   = 1'b1;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            default: d.st = CAL_IDLE;
        endcase
        if (abort) begin
            d.st  = CAL_IDLE;
            d.cnt = '0;
            fin   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: CAL_IDLE, full: 1'b0, cnt: '0};
        else        q <= d;
    end

    assign pend_short = (q.st != CAL_IDLE) && !q.full;
    assign pend_full  = (q.st != CAL_IDLE) &&  q.full;
    assign busy       = (q.st == CAL_BUSY);
    assign done_short = fin && !q.full;
    assign done_full  = fin &&  q.full;

endmodule

// File: rtl/acq_rst_seq.sv
module acq_rst_seq #(
    parameter int RST_CYC    = 2,
    parameter int SETTLE_CYC = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rst_load,
    input  logic stby,
    input  logic stby_exit,
    output logic rst_active,
    output logic stby_done
);

    localparam int RW = $clog2(RST_CYC + 1);
    localparam int SW = $clog2(SETTLE_CYC + 1);

    typedef struct packed {
        logic [RW-1:0] rcnt;
        logic [SW-1:0] scnt;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d = q;
        if (q.rcnt != '0) d.rcnt = q.rcnt - 1'b1;
        if (q.scnt != '0) d.scnt = q.scnt - 1'b1;
        if (rst_load || stby_exit) d.rcnt = RW'(RST_CYC);
        if (stby_exit)             d.scnt = SW'(SETTLE_CYC);
        else if (stby)             d.scnt = '0;
    end

    // power-on starts with the same clearing pulse as a commanded reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{rcnt: RW'(RST_CYC), scnt: '0};
        else        q <= d;
    end

    assign rst_active = (q.rcnt != '0) || stby;
    assign stby_done  = (q.scnt == SW'(1)) && !stby;

endmodule

// File: rtl/acq_sync_port.sv
module acq_sync_port (
    input  logic clk,
    input  logic rst_n,
    input  logic drive_out,
    input  logic conv_busy,
    input  logic sync_in,
    output logic sync_oe,
    output logic sync_out,
    output logic sync_trig
);

    typedef struct packed {
        logic cur;
        logic prev;
    } smp_t;

    smp_t q, d;

    always_comb begin
        d.cur  = sync_in;
        d.prev = q.cur;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sync_oe   = drive_out;
    assign sync_out  = drive_out && conv_busy;
    assign sync_trig = !drive_out && q.cur && !q.prev;

endmodule

// File: rtl/acq_ctrl_reg.sv
module acq_ctrl_reg
    import acq_ctrl_pkg::*;
#(
    parameter int SHORT_CYC  = 76,
    parameter int FULL_CYC   = 4944,
    parameter int RST_CYC    = 2,
    parameter int SETTLE_CYC = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    input  logic              instr_done,
    input  logic              conv_busy,
    input  logic              sync_in,
    output logic              seq_run,
    output logic              ip_reset,
    output logic              fifo_clr,
    output logic              irq_clr_all,
    output logic              irq_set_az,
    output logic              irq_set_cal,
    output logic              irq_set_stby,
    output logic              clk_en,
    output logic              chan_mask,
    output logic              az_each_conv,
    output logic [SECT_W-1:0] ram_sect,
    output logic              sync_oe,
    output logic              sync_out,
    output logic              sync_trig
);

    ctl_t q, d;

    logic rst_active, stby_done;
    logic pend_short, pend_full, cal_busy;
    logic stby_enter, stby_exit, rst_req, kill, cmd_ok;
    logic req_short, req_full;
    logic unused_hi;

    assign unused_hi = ^wr_data[REG_W-1:B_TEST+1];

    always_comb begin
        d          = q;
        stby_enter = wr_en &&  wr_data[B_STBY] && !q.stby;
        stby_exit  = wr_en && !wr_data[B_STBY] &&  q.stby;
        rst_req    = wr_en &&  wr_data[B_RST]  && !q.stby && !wr_data[B_STBY];
        kill       = rst_req || stby_enter || rst_active;
        cmd_ok     = wr_en && !rst_active && !wr_data[B_RST] && !wr_data[B_STBY];
        req_full   = cmd_ok && wr_data[B_CAL];
        req_short  = cmd_ok && wr_data[B_AZ] && !wr_data[B_CAL];

        if (wr_en) begin
            d.test     = wr_data[B_TEST];
            d.sync_dir = wr_data[B_SDIR];
            d.az_each  = wr_data[B_AZC];
            d.mask     = wr_data[B_MASK];
            d.stby     = wr_data[B_STBY];
            if (wr_data[B_SECT +: SECT_W] != SECT_BAD)
                d.sect = wr_data[B_SECT +: SECT_W];
        end

        if (kill) begin
            d.run       = 1'b0;
            d.stop_pend = 1'b0;
        end else if (cmd_ok) begin
            if (wr_data[B_RUN]) begin
                d.run       = 1'b1;
                d.stop_pend = 1'b0;
            end else begin
                // halt waits for the running instruction to complete
                d.run       = q.run && !instr_done;
                d.stop_pend = q.run && !instr_done;
            end
        end else if (q.stop_pend && instr_done) begin
            d.run       = 1'b0;
            d.stop_pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    acq_rst_seq #(
        .RST_CYC    (RST_CYC),
        .SETTLE_CYC (SETTLE_CYC)
    ) u_rst_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .rst_load   (rst_req),
        .stby       (q.stby),
        .stby_exit  (stby_exit),
        .rst_active (rst_active),
        .stby_done  (stby_done)
    );

    acq_cal_engine #(
        .SHORT_CYC (SHORT_CYC),
        .FULL_CYC  (FULL_CYC)
    ) u_cal (
        .clk         (clk),
        .rst_n       (rst_n),
        .abort       (kill),
        .req_short   (req_short),
        .req_full    (req_full),
        .seq_running (q.run),
        .instr_done  (instr_done),
        .pend_short  (pend_short),
        .pend_full   (pend_full),
        .busy        (cal_busy),
        .done_short  (irq_set_az),
        .done_full   (irq_set_cal)
    );

    acq_sync_port u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .drive_out (q.sync_dir),
        .conv_busy (conv_busy),
        .sync_in   (sync_in),
        .sync_oe   (sync_oe),
        .sync_out  (sync_out),
        .sync_trig (sync_trig)
    );

    always_comb begin
        rd_data                    = '0;
        rd_data[B_RUN]             = q.run;
        rd_data[B_RST]             = rst_active;
        rd_data[B_AZ]              = pend_short;
        rd_data[B_CAL]             = pend_full;
        rd_data[B_STBY]            = q.stby;
        rd_data[B_MASK]            = q.mask;
        rd_data[B_AZC]             = q.az_each;
        rd_data[B_SDIR]            = q.sync_dir;
        rd_data[B_SECT +: SECT_W]  = q.sect;
        rd_data[B_TEST]            = q.test;
    end

    assign seq_run      = q.run && !cal_busy && !rst_active;
    assign ip_reset     = rst_active;
    assign fifo_clr     = rst_active;
    assign irq_clr_all  = rst_active;
    assign irq_set_stby = stby_done;
    assign clk_en       = !q.stby;
    assign chan_mask    = q.mask;
    assign az_each_conv = q.az_each;
    assign ram_sect     = q.sect;

endmodule

// File: rtl/acq_ctrl_reg_chk.sv
module acq_ctrl_reg_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        instr_done,
    input logic [15:0] rd_data,
    input logic        seq_run,
    input logic        ip_reset,
    input logic        irq_set_az,
    input logic        irq_set_cal,
    input logic        irq_set_stby,
    input logic        clk_en,
    input logic [1:0]  ram_sect,
    input logic        sync_oe,
    input logic        sync_out
);

    logic unused_rd;
    assign unused_rd = ^rd_data[15:5];

    AST_RUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[0] && !instr_done && !wr_en |=> rd_data[0]); // R1

    AST_RST_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        ip_reset |-> !seq_run && !rd_data[0]); // R2

    AST_AZ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        irq_set_az |=> !rd_data[2]); // R4

    AST_CAL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_data[3:2])); // R5

    AST_CAL_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_set_az || irq_set_cal) |-> !seq_run); // R6

    AST_STBY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[4] |-> !clk_en && rd_data[1] && ip_reset); // R7

    AST_IRQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_set_az, irq_set_cal, irq_set_stby})); // R8

    AST_SYNC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_oe |-> !sync_out); // R9

    AST_SECT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        ram_sect != 2'b11); // R10

endmodule

bind acq_ctrl_reg acq_ctrl_reg_chk u_chk (.*);

// File: tb/acq_ctrl_reg_bench.sv
`timescale 1ns/1ps
module acq_ctrl_reg_bench;

    localparam int SHORT = 76;
    localparam int FULL  = 4944;
    localparam int SETTLE = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        instr_done = 1'b0;
    logic        conv_busy = 1'b0;
    logic        sync_in = 1'b0;
    logic        seq_run, ip_reset, fifo_clr, irq_clr_all;
    logic        irq_set_az, irq_set_cal, irq_set_stby, clk_en;
    logic        chan_mask, az_each_conv, sync_oe, sync_out, sync_trig;
    logic [1:0]  ram_sect;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int w_at  = 0;

    typedef struct {
        int kind;
        int at;
        int req;
    } exp_t;
    exp_t exp_q[$];
    exp_t got;
    int   kind_seen;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    acq_ctrl_reg #(
        .SHORT_CYC  (SHORT),
        .FULL_CYC   (FULL),
        .RST_CYC    (2),
        .SETTLE_CYC (SETTLE)
    ) u_acq_ctrl_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .instr_done(instr_done), .conv_busy(conv_busy),
        .sync_in(sync_in), .seq_run(seq_run), .ip_reset(ip_reset),
        .fifo_clr(fifo_clr), .irq_clr_all(irq_clr_all),
        .irq_set_az(irq_set_az), .irq_set_cal(irq_set_cal),
        .irq_set_stby(irq_set_stby), .clk_en(clk_en),
        .chan_mask(chan_mask), .az_each_conv(az_each_conv),
        .ram_sect(ram_sect), .sync_oe(sync_oe), .sync_out(sync_out),
        .sync_trig(sync_trig)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h cyc=%0d", req, act, exp, cyc);
        end
    endtask

    task automatic wr(input logic [15:0] v);
        wr_en   = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
        w_at    = cyc;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic done_pulse();
        instr_done = 1'b1;
        @(negedge clk);
        instr_done = 1'b0;
        w_at = cyc;
    endtask

    // driver side of the scoreboard: kind 0 short, 1 full, 2 standby
    task automatic expect_irq(input int kind, input int at, input int req);
        exp_t e;
        e.kind = kind;
        e.at   = at;
        e.req  = req;
        exp_q.push_back(e);
    endtask

    // monitor side: every interrupt strobe must match the oldest expectation
    always @(negedge clk) begin
        if (rst_n && (irq_set_az || irq_set_cal || irq_set_stby)) begin
            kind_seen = irq_set_az ? 0 : (irq_set_cal ? 1 : 2);
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R2 unexpected strobe act=kind%0d exp=none cyc=%0d", kind_seen, cyc);
            end else begin
                got = exp_q.pop_front();
                if (got.kind != kind_seen || got.at != cyc) begin
                    bad++;
                    $display("FAIL R%0d strobe act=kind%0d@%0d exp=kind%0d@%0d",
                             got.req, kind_seen, cyc, got.kind, got.at);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R1 watchdog act=%0d exp=done", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        // R3 power-on clearing pulse
        chk("R3", rd_data[1], 1);
        chk("R3", fifo_clr & ip_reset & irq_clr_all, 1);
        tick(1);
        chk("R3", rd_data[1], 1);
        tick(1);
        chk("R3", rd_data, 0);
        chk("R3", fifo_clr, 0);
        chk("R3", clk_en, 1);

        // R10 static fields
        wr(16'hFD60);
        chk("R10", rd_data, 16'h0560);
        chk("R10", {chan_mask, az_each_conv, ram_sect}, 4'b1101);
        wr(16'h0360);
        chk("R10", rd_data, 16'h0160);
        chk("R10", ram_sect, 1);
        wr(16'h0000);

        // R1 run and deferred halt
        wr(16'h0001);
        chk("R1", rd_data, 16'h0001);
        chk("R1", seq_run, 1);
        done_pulse();
        chk("R1", rd_data[0], 1);
        wr(16'h0000);
        chk("R1", {rd_data[0], seq_run}, 2'b11);
        tick(3);
        chk("R1", {rd_data[0], seq_run}, 2'b11);
        done_pulse();
        chk("R1", {rd_data[0], seq_run}, 2'b00);

        // R4 short correction while stopped, R5 request ignored while busy
        wr(16'h0004);
        chk("R4", rd_data[2], 1);
        expect_irq(0, w_at + SHORT - 1, 4);
        tick(9);
        wr(16'h0008);
        chk("R5", rd_data[3:2], 2'b01);
        tick(SHORT - 11);
        chk("R4", rd_data[2], 1);
        tick(1);
        chk("R4", rd_data[3:2], 2'b00);

        // R5 both bits written: full calibration only
        wr(16'h000C);
        chk("R5", rd_data[3:2], 2'b10);
        expect_irq(1, w_at + FULL - 1, 5);
        tick(FULL - 1);
        chk("R5", rd_data[3], 1);
        tick(1);
        chk("R5", rd_data[3:2], 2'b00);

        // R6 request deferred behind the running instruction
        wr(16'h0001);
        wr(16'h0005);
        chk("R6", {rd_data[2], seq_run}, 2'b11);
        tick(5);
        chk("R6", seq_run, 1);
        done_pulse();
        chk("R6", {rd_data[0], seq_run}, 2'b10);
        expect_irq(0, w_at + SHORT - 1, 6);
        tick(SHORT - 1);
        chk("R6", seq_run, 0);
        tick(1);
        chk("R6", {rd_data[2], rd_data[0], seq_run}, 3'b011);

        // R2 reset cancels a pending full calibration and halts
        wr(16'h0009);
        chk("R2", rd_data[3], 1);
        wr(16'h0002);
        chk("R2", {rd_data[3], rd_data[1], rd_data[0], seq_run}, 4'b0100);
        chk("R2", {ip_reset, fifo_clr, irq_clr_all}, 3'b111);
        wr(16'h0001);
        chk("R2", {rd_data[1], rd_data[0]}, 2'b10);
        tick(1);
        chk("R2", {rd_data[1], rd_data[0], fifo_clr}, 3'b000);

        // R7 standby entry, R11 commands ignored but fields writable
        wr(16'h0060);
        wr(16'h0070);
        chk("R7", clk_en, 0);
        chk("R7", rd_data, 16'h0072);
        chk("R7", {ip_reset, seq_run}, 2'b10);
        wr(16'h0075);
        chk("R11", rd_data, 16'h0072);
        wr(16'h0270);
        chk("R11", rd_data, 16'h0272);
        chk("R11", ram_sect, 2);
        tick(4);
        chk("R7", rd_data[1], 1);

        // R8 standby exit replays reset, then settle strobe
        wr(16'h0260);
        chk("R8", clk_en, 1);
        chk("R8", rd_data, 16'h0262);
        expect_irq(2, w_at + SETTLE - 1, 8);
        tick(1);
        chk("R8", rd_data[1], 1);
        tick(1);
        chk("R8", rd_data[1], 0);
        tick(SETTLE);

        // R9 sync pad in both directions
        conv_busy = 1'b1;
        sync_in   = 1'b1;
        tick(1);
        chk("R9", {sync_trig, sync_out, sync_oe}, 3'b100);
        tick(1);
        chk("R9", sync_trig, 0);
        sync_in = 1'b0;
        wr(16'h0080);
        chk("R9", {sync_oe, sync_out}, 2'b11);
        conv_busy = 1'b0;
        tick(2);
        chk("R9", sync_out, 0);
        sync_in = 1'b1;
        tick(1);
        chk("R9", sync_trig, 0);

        tick(4);
        chk("R5", exp_q.size(), 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule